// File: doc/BRIEF.md
# Walking-Bit Memory Pattern Tester

This block is a self-test engine for a memory whose words are 72 bits wide. After a start pulse it runs 144 passes over an inclusive address range set by the caller. In each pass it writes the whole range and then reads the whole range back. The first 72 passes use seeds that hold a single 1 among 0s. The next 72 passes use seeds that hold a single 0 among 1s. Within a pass the seed goes to the lowest address, and each later address receives the previous word rotated left by one bit. This way every bit lane of every word is exercised in both polarities.

Each word read back is compared with the regenerated expected word. Before the compare, both the expected word and the read word are masked per half: the upper 36 bits by one mask and the lower 36 bits by another. For bench-side probing, two programmable addresses can produce a one-cycle pulse in the cycle just before the engine writes or reads that address. The engine stops at the first mismatch and holds the failing address together with the raw expected and observed words.

The engine drives a plain synchronous single-port RAM with one cycle of read latency. All configuration inputs must stay stable while the engine is busy.

Top module: `walkbit_bist`

## Requirements
- R1: After reset, `busy`, `done`, `fail`, `memWe`, `wrTrig` and `rdTrig` are all low.
- R2: A start pulse runs 144 passes. The seeds are 72 one-hot words, bit 0 first and rising, followed by 72 words with a single 0, bit 0 first and rising. After a clean final pass `done` goes high and stays high until the next start. When the run ends, address lo+k holds the complement of (1 << ((71+k) mod 72)).
- R3: Within a pass, the word written to each address after the first equals the previous word rotated left by one bit over all 72 bits.
- R4: Every pass writes each address from `loAddr` to `hiAddr` inclusive, and then reads each of them. Each read address is held for one cycle before its data is sampled. No address outside the range is written.
- R5: Bits [71:36] of the expected and read words are ANDed with `leftMask`, and bits [35:0] with `rightMask`, before the compare. A difference only in masked-off bits is not a failure.
- R6: On the first mismatch the engine stops and raises `fail`. It holds `failAddr`, `failExp` (the unmasked expected word) and `failObs` (the raw read word) until the next start. `fail` and `done` are never high together.
- R7: When `wrTrigAddr` lies in the range, `wrTrig` pulses for one cycle immediately before each write to that address, which gives one pulse per pass.
- R8: When `rdTrigAddr` lies in the range, `rdTrig` pulses for one cycle immediately before the read address of that location is presented, which gives one pulse per pass.
- R9: A trigger address of zero disables that trigger, even when address 0 is inside the range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (accepted while not busy) |
| loAddr | input | ADDR_W | First address of the range |
| hiAddr | input | ADDR_W | Last address of the range (>= loAddr) |
| leftMask | input | 36 | Compare mask for bits [71:36] |
| rightMask | input | 36 | Compare mask for bits [35:0] |
| wrTrigAddr | input | ADDR_W | Write trigger address, 0 = off |
| rdTrigAddr | input | ADDR_W | Read trigger address, 0 = off |
| memAddr | output | ADDR_W | RAM address |
| memWdata | output | 72 | RAM write data |
| memWe | output | 1 | RAM write enable |
| memRdata | input | 72 | RAM read data, one cycle after address |
| wrTrig | output | 1 | Pulse before a write to the trigger address |
| rdTrig | output | 1 | Pulse before a read of the trigger address |
| busy | output | 1 | Run in progress |
| done | output | 1 | All passes completed cleanly |
| fail | output | 1 | Mismatch found |
| failAddr | output | ADDR_W | Address of the first mismatch |
| failExp | output | 72 | Expected word at the failure, unmasked |
| failObs | output | 72 | Read word at the failure |

## Verification
A wrong seed register or a broken rotate shows up at `memWdata` on the very first write that uses it, and it also leaves the RAM in a final state other than the required complement pattern. An off-by-one in the address walk either writes outside the range, which shows in the neighbouring words, or skips the last word. A slip in the read-latency handling makes a clean memory report `fail` on the first read of pass 0. Trigger faults change the pulse count away from one per pass, or place the following access at the wrong address.

// File: rtl/wbt_pkg.sv
package wbt_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_WSET, S_WRITE, S_RSET, S_RADDR, S_RCMP, S_DONE, S_FAIL
  } wbt_state_e;

  typedef struct packed {
    logic loadSeed;   // seed <= one-hot bit 0
    logic advSeed;    // seed <= next pass seed
    logic seedFlip;   // with advSeed: switch to the single-zero family
    logic loadCur;    // cur <= seed, addr <= loAddr
    logic stepCur;    // cur <= rotl(cur), addr <= addr + 1
    logic captureFail;
  } wbt_strobe_t;

endpackage

// File: rtl/wbt_ctrl.sv
module wbt_ctrl
  import wbt_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 72
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              atHi,
  input  logic              mismatch,
  input  logic [ADDR_W-1:0] loAddr,
  input  logic [ADDR_W-1:0] addrPlus,
  input  logic [ADDR_W-1:0] wrTrigAddr,
  input  logic [ADDR_W-1:0] rdTrigAddr,
  output wbt_strobe_t       strobe,
  output logic              memWe,
  output logic              wrTrig,
  output logic              rdTrig,
  output logic              busy,
  output logic              done,
  output logic              fail
);
  localparam int PASS_CNT  = 2 * DATA_W;
  localparam int FLIP_PASS = DATA_W - 1;
  localparam int PCW       = $clog2(PASS_CNT);

  wbt_state_e st, stNext;
  logic [PCW-1:0] passCnt, passNext;
  logic lastPass;

  assign lastPass = (passCnt == PCW'(PASS_CNT - 1));

  always_comb begin
    stNext   = st;
    passNext = passCnt;
    strobe   = '0;
    unique case (st)
      S_IDLE, S_DONE, S_FAIL: begin
        if (start) begin
          strobe.loadSeed = 1'b1;
          passNext        = '0;
          stNext          = S_WSET;
        end
      end
      S_WSET: begin
        strobe.loadCur = 1'b1;
        stNext         = S_WRITE;
      end
      S_WRITE: begin
        if (atHi) stNext = S_RSET;
        else strobe.stepCur = 1'b1;
      end
      S_RSET: begin
        strobe.loadCur = 1'b1;
        stNext         = S_RADDR;
      end
      S_RADDR: stNext = S_RCMP;
      S_RCMP: begin
        if (mismatch) begin
          strobe.captureFail = 1'b1;
          stNext             = S_FAIL;
        end else if (atHi) begin
          if (lastPass) begin
            stNext = S_DONE;
          end else begin
            strobe.advSeed  = 1'b1;
            strobe.seedFlip = (passCnt == PCW'(FLIP_PASS));
            passNext        = passCnt + 1'b1;
            stNext          = S_WSET;
          end
        end else begin
          strobe.stepCur = 1'b1;
          stNext         = S_RADDR;
        end
      end
      default: stNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st      <= S_IDLE;
      passCnt <= '0;
    end else begin
      st      <= stNext;
      passCnt <= passNext;
    end
  end

  // Trigger pulses look one access ahead of the address walk.
  logic wrArmed, rdArmed;
  assign wrArmed = (wrTrigAddr != '0);
  assign rdArmed = (rdTrigAddr != '0);

  assign wrTrig = wrArmed &&
                  ((st == S_WSET && loAddr == wrTrigAddr) ||
                   (st == S_WRITE && !atHi && addrPlus == wrTrigAddr));
  assign rdTrig = rdArmed &&
                  ((st == S_RSET && loAddr == rdTrigAddr) ||
                   (st == S_RCMP && !mismatch && !atHi && addrPlus == rdTrigAddr));

  assign memWe = (st == S_WRITE);
  assign busy  = (st != S_IDLE) && (st != S_DONE) && (st != S_FAIL);
  assign done  = (st == S_DONE);
  assign fail  = (st == S_FAIL);

endmodule

// File: rtl/wbt_datapath.sv
module wbt_datapath
  import wbt_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 72
) (
  input  logic                clk,
  input  logic                rstN,
  input  wbt_strobe_t         strobe,
  input  logic [ADDR_W-1:0]   loAddr,
  input  logic [ADDR_W-1:0]   hiAddr,
  input  logic [DATA_W/2-1:0] leftMask,
  input  logic [DATA_W/2-1:0] rightMask,
  input  logic [DATA_W-1:0]   memRdata,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWdata,
  output logic [ADDR_W-1:0]   addrPlus,
  output logic                atHi,
  output logic                mismatch,
  output logic [ADDR_W-1:0]   failAddr,
  output logic [DATA_W-1:0]   failExp,
  output logic [DATA_W-1:0]   failObs
);
  localparam logic [DATA_W-1:0] ONE_HOT0 = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] seed, cur, cmpMask;
  logic [ADDR_W-1:0] addr;

  function automatic logic [DATA_W-1:0] rotl(input logic [DATA_W-1:0] x);
    return {x[DATA_W-2:0], x[DATA_W-1]};
  endfunction

  assign cmpMask  = {leftMask, rightMask};
  assign mismatch = |((memRdata ^ cur) & cmpMask);
  assign atHi     = (addr == hiAddr);
  assign addrPlus = addr + 1'b1;
  assign memAddr  = addr;
  assign memWdata = cur;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seed     <= '0;
      cur      <= '0;
      addr     <= '0;
      failAddr <= '0;
      failExp  <= '0;
      failObs  <= '0;
    end else begin
      if (strobe.loadSeed)     seed <= ONE_HOT0;
      else if (strobe.advSeed) seed <= strobe.seedFlip ? ~ONE_HOT0 : rotl(seed);

      if (strobe.loadCur) begin
        cur  <= seed;
        addr <= loAddr;
      end else if (strobe.stepCur) begin
        cur  <= rotl(cur);
        addr <= addrPlus;
      end

      if (strobe.captureFail) begin
        failAddr <= addr;
        failExp  <= cur;
        failObs  <= memRdata;
      end
    end
  end

endmodule

// File: rtl/walkbit_bist.sv
module walkbit_bist
  import wbt_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 72
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [ADDR_W-1:0]   loAddr,
  input  logic [ADDR_W-1:0]   hiAddr,
  input  logic [DATA_W/2-1:0] leftMask,
  input  logic [DATA_W/2-1:0] rightMask,
  input  logic [ADDR_W-1:0]   wrTrigAddr,
  input  logic [ADDR_W-1:0]   rdTrigAddr,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWdata,
  output logic                memWe,
  input  logic [DATA_W-1:0]   memRdata,
  output logic                wrTrig,
  output logic                rdTrig,
  output logic                busy,
  output logic                done,
  output logic                fail,
  output logic [ADDR_W-1:0]   failAddr,
  output logic [DATA_W-1:0]   failExp,
  output logic [DATA_W-1:0]   failObs
);
  wbt_strobe_t       strobe;
  logic              atHi, mismatch;
  logic [ADDR_W-1:0] addrPlus;

  wbt_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .atHi(atHi), .mismatch(mismatch),
    .loAddr(loAddr), .addrPlus(addrPlus), .wrTrigAddr(wrTrigAddr),
    .rdTrigAddr(rdTrigAddr), .strobe(strobe), .memWe(memWe),
    .wrTrig(wrTrig), .rdTrig(rdTrig), .busy(busy), .done(done), .fail(fail)
  );

  wbt_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loAddr(loAddr), .hiAddr(hiAddr),
    .leftMask(leftMask), .rightMask(rightMask), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .addrPlus(addrPlus), .atHi(atHi),
    .mismatch(mismatch), .failAddr(failAddr), .failExp(failExp), .failObs(failObs)
  );

endmodule

// File: rtl/wbt_checker.sv
module wbt_checker #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 72
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [ADDR_W-1:0] loAddr,
  input logic [ADDR_W-1:0] hiAddr,
  input logic [ADDR_W-1:0] wrTrigAddr,
  input logic [ADDR_W-1:0] rdTrigAddr,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWdata,
  input logic              memWe,
  input logic              wrTrig,
  input logic              rdTrig,
  input logic              busy,
  input logic              done,
  input logic              fail,
  input logic [ADDR_W-1:0] failAddr
);
  logic              prevWe;
  logic [DATA_W-1:0] prevWdata;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevWe    <= 1'b0;
      prevWdata <= '0;
    end else begin
      prevWe    <= memWe;
      prevWdata <= memWdata;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rstN |=> !busy && !done && !fail && !memWe); // R1
  AST_SEED_WEIGHT: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> ($countones(memWdata) == 1 || $countones(memWdata) == DATA_W-1)); // R2
  AST_WR_ROTATE: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && prevWe) |-> memWdata == {prevWdata[DATA_W-2:0], prevWdata[DATA_W-1]}); // R3
  AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memAddr >= loAddr && memAddr <= hiAddr)); // R4
  AST_DONE_FAIL_EXCL: assert property (@(posedge clk) disable iff (!rstN) !(done && fail)); // R6
  AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (fail && !start) |=> fail && failAddr == $past(failAddr)); // R6
  AST_WR_TRIG_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    wrTrig |=> memWe && memAddr == $past(wrTrigAddr)); // R7
  AST_RD_TRIG_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    rdTrig |=> !memWe && memAddr == $past(rdTrigAddr)); // R8
  AST_TRIG_ZERO_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (wrTrig -> wrTrigAddr != '0) && (rdTrig -> rdTrigAddr != '0)); // R9

endmodule

bind walkbit_bist wbt_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .loAddr(loAddr), .hiAddr(hiAddr),
  .wrTrigAddr(wrTrigAddr), .rdTrigAddr(rdTrigAddr), .memAddr(memAddr),
  .memWdata(memWdata), .memWe(memWe), .wrTrig(wrTrig), .rdTrig(rdTrig),
  .busy(busy), .done(done), .fail(fail), .failAddr(failAddr)
);

// File: tb/walkbit_bist_bench.sv
module walkbit_bist_bench;
  localparam int AW = 8;
  localparam int DW = 72;
  localparam logic [35:0] ALL1 = 36'hF_FFFF_FFFF;
  localparam logic [71:0] MARK = 72'h5A;

  typedef struct packed {
    logic [7:0]  lo;
    logic [7:0]  hi;
    logic [7:0]  trigW;
    logic [7:0]  trigR;
    logic [35:0] lmask;
    logic [35:0] rmask;
    logic        corrupt;
    logic [7:0]  cAddr;
    logic [6:0]  cBit;
    logic        expFail;
    logic [8:0]  expWr;
    logic [8:0]  expRd;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{8'd0,  8'd7,  8'd3,  8'd7,  ALL1,           ALL1, 1'b0, 8'd0,  7'd0,  1'b0, 9'd144, 9'd144},
    '{8'd20, 8'd35, 8'd20, 8'd40, ALL1,           ALL1, 1'b0, 8'd0,  7'd0,  1'b0, 9'd144, 9'd0},
    '{8'd0,  8'd3,  8'd0,  8'd0,  ALL1,           ALL1, 1'b0, 8'd0,  7'd0,  1'b0, 9'd0,   9'd0},
    '{8'd5,  8'd12, 8'd0,  8'd0,  ALL1,           ALL1, 1'b1, 8'd9,  7'd40, 1'b1, 9'd0,   9'd0},
    '{8'd5,  8'd12, 8'd0,  8'd0,  36'hF_FFFF_FFEF, ALL1, 1'b1, 8'd9,  7'd40, 1'b0, 9'd0,   9'd0},
    '{8'd50, 8'd50, 8'd50, 8'd50, ALL1,           ALL1, 1'b0, 8'd0,  7'd0,  1'b0, 9'd144, 9'd144},
    '{8'd12, 8'd15, 8'd13, 8'd0,  ALL1,           ALL1, 1'b1, 8'd12, 7'd0,  1'b1, 9'd1,   9'd0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] loAddr = '0, hiAddr = '0, wrTrigAddr = '0, rdTrigAddr = '0;
  logic [35:0] leftMask = ALL1, rightMask = ALL1;
  logic [AW-1:0] memAddr, failAddr;
  logic [DW-1:0] memWdata, memRdata, failExp, failObs;
  logic memWe, wrTrig, rdTrig, busy, done, fail;

  always #2 clk = ~clk;

  walkbit_bist #(.ADDR_W(AW), .DATA_W(DW)) u_walkbit_bist (
    .clk(clk), .rstN(rstN), .start(start), .loAddr(loAddr), .hiAddr(hiAddr),
    .leftMask(leftMask), .rightMask(rightMask), .wrTrigAddr(wrTrigAddr),
    .rdTrigAddr(rdTrigAddr), .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe),
    .memRdata(memRdata), .wrTrig(wrTrig), .rdTrig(rdTrig), .busy(busy), .done(done),
    .fail(fail), .failAddr(failAddr), .failExp(failExp), .failObs(failObs)
  );

  // RAM model, one-cycle read latency, optional read corruption
  logic [DW-1:0] ram [2**AW];
  logic corrupt = 1'b0;
  logic [AW-1:0] cAddr = '0;
  logic [6:0] cBit = '0;
  initial begin
    for (int j = 0; j < 2**AW; j++) ram[j] = MARK;
    memRdata = '0;
  end
  always @(posedge clk) begin
    if (memWe) ram[memAddr] <= memWdata;
    memRdata <= ram[memAddr] ^ ((corrupt && memAddr == cAddr) ? (72'd1 << cBit) : 72'd0);
  end

  // Trigger observers
  int wrCnt = 0, rdCnt = 0, trigBad = 0;
  logic seenW = 1'b0, seenR = 1'b0;
  always @(negedge clk) begin
    if (seenW) begin
      if (memWe && memAddr == wrTrigAddr) wrCnt++; else trigBad++;
    end
    if (seenR) begin
      if (!memWe && memAddr == rdTrigAddr) rdCnt++; else trigBad++;
    end
    seenW = rstN && wrTrig;
    seenR = rstN && rdTrig;
  end

  int nChecks = 0, nFail = 0, cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc >= 190000) begin
      nFail++;
      $display("FAIL watchdog: run hung (actual cycles %0d, expected < 190000)", cyc);
      $display("[TB] %0d tests run, %0d failed", nChecks + 1, nFail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !fail, "R1 status", {busy, done, fail}, 0);
    chk(!memWe && !wrTrig && !rdTrig, "R1 strobes", {memWe, wrTrig, rdTrig}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !fail && !memWe, "R1 idle after reset", {busy, done, fail, memWe}, 0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      int n, waitCyc;
      logic [71:0] eExp, eObs;
      v = VECS[i];
      loAddr = v.lo; hiAddr = v.hi; wrTrigAddr = v.trigW; rdTrigAddr = v.trigR;
      leftMask = v.lmask; rightMask = v.rmask;
      corrupt = v.corrupt; cAddr = v.cAddr; cBit = v.cBit;
      wrCnt = 0; rdCnt = 0; trigBad = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy && !done && !fail, "R2 busy after start", {busy, done, fail}, 3'b100);
      waitCyc = 0;
      while (!done && !fail && waitCyc < 30000) begin
        @(negedge clk);
        waitCyc++;
      end
      n = v.hi - v.lo + 1;
      if (v.expFail) begin
        // R6: first mismatch is in pass 0 at the corrupted address
        eExp = 72'd1 << ((v.cAddr - v.lo) % 72);
        eObs = eExp ^ (72'd1 << v.cBit);
        chk(fail && !done, "R6 fail flag", {done, fail}, 2'b01);
        chk(failAddr == v.cAddr, "R6 fail address", failAddr, v.cAddr);
        chk(failExp == eExp, "R6 expected word", failExp, eExp);
        chk(failObs == eObs, "R6 observed word", failObs, eObs);
        repeat (4) @(negedge clk);
        chk(fail && failAddr == v.cAddr && !busy, "R6 hold", {fail, failAddr}, {1'b1, v.cAddr});
      end else begin
        chk(done && !fail, (i == 4) ? "R5 masked difference ignored" : "R2 done",
            {done, fail}, 2'b10);
        // R2 / R3: final pass leaves complement of rotated bit 71
        for (int k = 0; k < n; k++) begin
          logic [71:0] want;
          want = ~(72'd1 << ((71 + k) % 72));
          chk(ram[v.lo + k] == want, "R3 final RAM word", ram[v.lo + k], want);
        end
        repeat (3) @(negedge clk);
        chk(done && !busy, "R2 done holds", {done, busy}, 2'b10);
      end
      chk(wrCnt == v.expWr, (v.trigW == 0) ? "R9 write trigger off" : "R7 write trigger count",
          wrCnt, v.expWr);
      chk(rdCnt == v.expRd, (v.trigR == 0) ? "R9 read trigger off" : "R8 read trigger count",
          rdCnt, v.expRd);
      chk(trigBad == 0, "R7 trigger placement", trigBad, 0);
      if (i == 1) begin
        // R4: neighbours of the range untouched
        chk(ram[19] == MARK, "R4 below range", ram[19], MARK);
        chk(ram[36] == MARK, "R4 above range", ram[36], MARK);
      end
    end

    // restart after a failure clears fail and runs cleanly
    loAddr = 8'd60; hiAddr = 8'd61; wrTrigAddr = '0; rdTrigAddr = '0;
    leftMask = ALL1; rightMask = ALL1; corrupt = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!fail && busy, "R6 restart clears fail", {fail, busy}, 2'b01);
    while (!done && !fail) @(negedge clk);
    chk(done && ram[61] == ~(72'd1), "R4 two-word range", ram[61], ~(72'd1));

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule